// File: doc/BRIEF.md
# GPIO Interrupt Status Aggregator

This block folds the pending flags of up to 184 GPIO pins into a compact summary that a processor can scan quickly. Pins are grouped four at a time, and each group owns one summary bit that is set whenever any pin in the group has a pending flag. Software reads the summary through two 32-bit words and then visits only the per-pin status registers of groups whose bit is set. Each pin's register sits at a 4-byte stride, so group k covers byte offsets 16k to 16k+12 in the pin region.

The block also drives one interrupt line to the processor. The line gives a single-cycle pulse when anything is pending and delivery is armed. Delivery then stays disarmed until software writes the end-of-interrupt bit in the control word after servicing. The summary is purely combinational from the pin flags, so a read always shows the present state.

Top module: `gpio_irq_summary`

## Requirements
- R1: Reading byte offset 0x0 returns summary bits 0 to 31, where summary bit k is the OR of the pending flags of pins 4k, 4k+1, 4k+2 and 4k+3.
- R2: Reading byte offset 0x4 returns summary bits 32 to 45 in data bits 0 to 13, and data bits 14 to 31 read as zero.
- R3: Byte offset 0x8 is the control word, with end-of-interrupt at data bit 0. The bit is self-clearing, and the whole word always reads as zero.
- R4: While reset is asserted and right after it, the interrupt output is low and delivery is armed.
- R5: When delivery is armed and any summary bit is set at a rising clock edge, the interrupt output is high for exactly the following clock cycle and delivery becomes disarmed.
- R6: While delivery is disarmed, the interrupt output stays low whatever the pin flags do.
- R7: A write to offset 0x8 with data bit 0 set re-arms delivery. If a summary bit is still set, the next pulse starts one cycle after the write edge. Otherwise the next pulse follows the first edge that sees a pending flag. An end-of-interrupt written on the same edge that launches a pulse has no further effect.
- R8: Writes to offsets 0x0 and 0x4, and writes to 0x8 with data bit 0 clear, do not re-arm delivery and do not change any read value.
- R9: Reads of any byte offset other than 0x0, 0x4 and 0x8 return zero.
- R10: Summary reads are not latched. A change on the pin flags is visible in the read data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_pending | input | 184 | Pending flag for each pin |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Single-cycle interrupt pulse to the processor |

## Verification
The hardest case to reach is an end-of-interrupt write that lands on the same edge that launches a pulse, because the re-arm must then be absorbed rather than cause a second pulse. Directed sequences hold a flag pending across many cycles and interleave writes that must not re-arm with writes that must. A long random phase then issues end-of-interrupt writes often while flags come and go. This makes coincident edges frequent, and a behavioural model checks the pulse line on every clock.

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int NUM_PINS       = 184,
  parameter int PINS_PER_GROUP = 4,
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 4,
  parameter int EOI_BIT        = 0,
  parameter logic [ADDR_W-1:0] LOW_OFS  = 4'h0,
  parameter logic [ADDR_W-1:0] HIGH_OFS = 4'h4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 4'h8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_pending,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rd_data,
  output logic                irq_out
);
  localparam int NUM_GROUPS = (NUM_PINS + PINS_PER_GROUP - 1) / PINS_PER_GROUP;
  localparam int SUM_W      = 2 * DATA_W;

  logic [SUM_W-1:0] summary;
  logic             armed_q;
  logic             fire;
  logic             eoi_wr;
  logic             unused_wdata;

  for (genvar g = 0; g < SUM_W; g++) begin : g_sum
    if (g < NUM_GROUPS) begin : g_live
      logic [PINS_PER_GROUP-1:0] members;
      for (genvar m = 0; m < PINS_PER_GROUP; m++) begin : g_mem
        if (g * PINS_PER_GROUP + m < NUM_PINS) begin : g_pin
          assign members[m] = pin_pending[g*PINS_PER_GROUP+m];
        end else begin : g_pad
          assign members[m] = 1'b0;
        end
      end
      assign summary[g] = |members;
    end else begin : g_zero
      assign summary[g] = 1'b0;
    end
  end

  assign eoi_wr       = reg_wr && (reg_addr == CTRL_OFS) && reg_wdata[EOI_BIT];
  assign fire         = armed_q && (|summary);
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    case (reg_addr)
      LOW_OFS:  reg_rd_data = summary[DATA_W-1:0];
      HIGH_OFS: reg_rd_data = summary[SUM_W-1:DATA_W];
      default:  reg_rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_out <= 1'b0;
    end else begin
      irq_out <= fire;
      if (fire)        armed_q <= 1'b0;
      else if (eoi_wr) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_summary_chk.sv
module gpio_irq_summary_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int EOI_BIT = 0,
  parameter logic [ADDR_W-1:0] LOW_OFS  = 4'h0,
  parameter logic [ADDR_W-1:0] HIGH_OFS = 4'h4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 4'h8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rd_data,
  input logic              irq_out
);
  logic eoi_now;
  logic rearm_seen;
  assign eoi_now = reg_wr && (reg_addr == CTRL_OFS) && reg_wdata[EOI_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rearm_seen <= 1'b1;
    else if (irq_out)  rearm_seen <= eoi_now;
    else if (eoi_now)  rearm_seen <= 1'b1;
  end

  a_r4_quiet_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !irq_out);
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n) irq_out |=> !irq_out);
  a_r6_needs_rearm: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> rearm_seen);
  a_r3_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_OFS) |-> (reg_rd_data == '0));
  a_r2_high_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == HIGH_OFS) |-> (reg_rd_data[DATA_W-1:14] == '0));
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != LOW_OFS && reg_addr != HIGH_OFS && reg_addr != CTRL_OFS) |-> (reg_rd_data == '0));
endmodule

bind gpio_irq_summary gpio_irq_summary_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EOI_BIT(EOI_BIT),
  .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS), .CTRL_OFS(CTRL_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data), .irq_out(irq_out)
);

// File: tb/gpio_irq_summary_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_summary_tb_top;
  localparam int NP = 184;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pend = '0;
  logic [3:0]    addr = 4'h0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rd_data;
  logic          irq_out;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_summary dut_i (
    .clk(clk), .rst_n(rst_n), .pin_pending(pend), .reg_addr(addr),
    .reg_wr(wr), .reg_wdata(wdata), .reg_rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [63:0] exp_sum(input logic [NP-1:0] p);
    logic [63:0] s = '0;
    for (int k = 0; k < 46; k++)
      s[k] = p[4*k] | p[4*k+1] | p[4*k+2] | p[4*k+3];
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input logic [NP-1:0] p, input logic [3:0] a);
    logic [63:0] s = exp_sum(p);
    if (a == 4'h0) return s[31:0];
    if (a == 4'h4) return s[63:32];
    return 32'h0;
  endfunction

  // Behavioural reference for the pulse line
  bit ref_armed = 1;
  bit exp_irq = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_armed <= 1;
      exp_irq   <= 0;
    end else if (ref_armed && exp_sum(pend) != 0) begin
      exp_irq   <= 1;
      ref_armed <= 0;
    end else begin
      exp_irq <= 0;
      if (wr && addr == 4'h8 && wdata[0]) ref_armed <= 1;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [NP-1:0] p, input logic [3:0] a, input logic w, input logic [31:0] d);
    string tag;
    @(negedge clk);
    pend = p; addr = a; wr = w; wdata = d;
    #1;
    if (a == 4'h0) tag = "R1 low word / R10";
    else if (a == 4'h4) tag = "R2 high word / R10";
    else if (a == 4'h8) tag = "R3 control reads zero";
    else tag = "R9 unmapped";
    check(tag, rd_data, exp_read(p, a));
    check("R5 pulse line vs model", irq_out, exp_irq);
    if (irq_out) pulses++;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NP-1:0] p;
    int base;
    #5;
    check("R4 irq low in reset", irq_out, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R4 irq low after reset", irq_out, 0);

    cyc('0, 4'h0, 0, 0);
    cyc('0, 4'h4, 0, 0);
    cyc('0, 4'h8, 0, 0);
    cyc('0, 4'hC, 0, 0);
    cyc('0, 4'h2, 0, 0);

    // R5 and R6: a held flag gives one pulse only
    p = '0; p[0] = 1'b1;
    base = pulses;
    repeat (12) cyc(p, 4'h0, 0, 0);
    check("R6 one pulse while disarmed", pulses - base, 1);
    // R8: writes that must not re-arm
    cyc(p, 4'h0, 1, 32'hFFFF_FFFF);
    cyc(p, 4'h4, 1, 32'h1);
    cyc(p, 4'h8, 1, 32'h2);
    repeat (5) cyc(p, 4'h0, 0, 0);
    check("R8 no re-arm from other writes", pulses - base, 1);
    // R7: end-of-interrupt with flag still set
    cyc(p, 4'h8, 1, 32'h1);
    repeat (3) cyc(p, 4'h8, 0, 0);
    check("R7 re-pulse after eoi", pulses - base, 2);

    // R7: eoi with nothing pending waits for a flag
    cyc('0, 4'h8, 1, 32'h1);
    base = pulses;
    repeat (6) cyc('0, 4'h4, 0, 0);
    check("R7 no pulse when idle", pulses - base, 0);
    p = '0; p[183] = 1'b1;
    repeat (3) cyc(p, 4'h4, 0, 0);
    check("R7 pulse on late flag", pulses - base, 1);
    check("R2 top group read", rd_data, 32'h0000_2000);

    // R1/R2: walk one pin per group
    for (int k = 0; k < 46; k++) begin
      p = '0; p[4*k + (k % 4)] = 1'b1;
      cyc(p, (k < 32) ? 4'h0 : 4'h4, 0, 0);
      cyc(p, (k < 32) ? 4'h4 : 4'h0, 1, 32'h0);
    end

    // Random traffic with frequent eoi writes
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] a;
      p = '0;
      for (int b = 0; b < NP; b++) if ($urandom_range(0, 40) == 0) p[b] = 1'b1;
      if ($urandom_range(0, 3) == 0) p = '0;
      case ($urandom_range(0, 4))
        0: a = 4'h0;
        1: a = 4'h4;
        2: a = 4'h8;
        3: a = 4'hC;
        default: a = 4'(2 * $urandom_range(0, 7) + 1);
      endcase
      if ($urandom_range(0, 2) == 0) cyc(p, 4'h8, 1, 32'h1);
      else cyc(p, a, $urandom_range(0, 1) == 1, $urandom);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule